// File: doc/BRIEF.md
# GPIO Configuration Register Bank with Key Lock

This block is the software-facing configuration store of a 32-pin general purpose I/O controller. A simple word-wide bus writes and reads the registers for output value, drive enable, inversion, open-drain selection, pull resistors, input gating, event mode and event enable. The pin-resolution and event logic sit beside the bank. They take the register contents as plain vectors, return the resolved pin levels and the event flags for read-back, and receive the event-flag clears that software writes.

Set and clear aliases change single bits of the output value, drive enable and event enable vectors in one write, without a read-modify-write. A key lock guards the configuration. Any write to either lock register closes the bank, and it reopens only when the two keys arrive in the correct order on back-to-back bank writes.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset the bank is open, every configuration output is zero except `cfg_ien`, which is all ones, and `evt_clr` is zero.
- R2: A write to output value (0x0C), drive enable (0x10), inversion (0x08), open-drain (0x14), pull-up (0x1C), pull-down (0x20), event mode (0x28), both-edge (0x2C), event enable (0x40) or input gating (0x58) stores the word. That word appears on the matching `cfg_*` output after the write edge and reads back unchanged.
- R3: A write to a set alias ORs the written bits into its target: 0x68 targets output value, 0x70 drive enable, and 0x44 event enable.
- R4: A write to a clear alias clears the written bits of its target: 0x6C targets output value, 0x74 drive enable, and 0x48 event enable. For example, drive enable 0x3456789A cleared with 0x00030002 becomes 0x34547898.
- R5: While the bank is open, a write of any value to lock register A (0x00) or lock register B (0x7C) closes it. Reading 0x00 returns 1 while closed and 0 while open, and `bank_locked` follows the same state.
- R6: While the bank is closed, writes to every configuration register and every set or clear alias leave all `cfg_*` outputs unchanged.
- R7: The bank reopens only when 0xC0DE1248 is written to 0x7C and the very next bus write puts 0xC0DEFA73 into 0x00. A wrong key, a wrong order or any other write in between leaves it closed.
- R8: A write to event status (0x4C) drives the written word on `evt_clr` for exactly the following cycle, whether the bank is open or closed. In every other cycle `evt_clr` is zero.
- R9: Reading 0x04 returns `pin_level` and reading 0x4C returns `evt_status`. A write to 0x04 changes no output.
- R10: `bus_rdata` is loaded at the clock edge where `bus_rd` is high and holds otherwise. Lock register B, the aliases, unmapped and misaligned offsets read zero, and writes to unmapped or misaligned offsets change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_level | input | 32 | Resolved pin levels from the pin logic |
| evt_status | input | 32 | Event flags from the event logic |
| cfg_dout | output | 32 | Output value vector |
| cfg_oe | output | 32 | Drive enable vector |
| cfg_pol | output | 32 | Inversion vector |
| cfg_otype | output | 32 | Open-drain select vector |
| cfg_pu | output | 32 | Pull-up vector |
| cfg_pd | output | 32 | Pull-down vector |
| cfg_ien | output | 32 | Input gating vector |
| cfg_evtype | output | 32 | Event mode vector (edge or level) |
| cfg_evboth | output | 32 | Both-edge select vector |
| cfg_even | output | 32 | Event enable vector |
| evt_clr | output | 32 | One-cycle event-flag clear pulse |
| bank_locked | output | 1 | High while the bank is closed |

## Verification
Some properties are checked on every cycle. A closed bank freezes all configuration outputs. A closed bank never reopens except through the half-keyed state, and any stray write in that state closes it again. Set and clear aliases leave the written bits set or cleared. `evt_clr` stays zero outside the cycle after an event-status write, and read data holds when no read is strobed. Other behaviour only the scenarios can show: the exact stored values, the reset contents, the read-back of the pin and event inputs, and the zero read of aliases and unmapped offsets. So can the specific key sequences, such as a second key without the first or an intervening write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PIN_W = 32;

    // byte offsets; the lock registers and aliases must sit where software expects them
    localparam int OFS_LOCK_A   = 'h00;
    localparam int OFS_DIN      = 'h04;
    localparam int OFS_POL      = 'h08;
    localparam int OFS_DOUT     = 'h0C;
    localparam int OFS_OE       = 'h10;
    localparam int OFS_OTYPE    = 'h14;
    localparam int OFS_PU       = 'h1C;
    localparam int OFS_PD       = 'h20;
    localparam int OFS_EVTYPE   = 'h28;
    localparam int OFS_EVBOTH   = 'h2C;
    localparam int OFS_EVEN     = 'h40;
    localparam int OFS_EVEN_SET = 'h44;
    localparam int OFS_EVEN_CLR = 'h48;
    localparam int OFS_EVST     = 'h4C;
    localparam int OFS_IEN      = 'h58;
    localparam int OFS_DOUT_SET = 'h68;
    localparam int OFS_DOUT_CLR = 'h6C;
    localparam int OFS_OE_SET   = 'h70;
    localparam int OFS_OE_CLR   = 'h74;
    localparam int OFS_LOCK_B   = 'h7C;

    typedef enum logic [1:0] {
        LK_OPEN = 2'd0,
        LK_SHUT = 2'd1,
        LK_HALF = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic lock_a;
        logic din;
        logic pol;
        logic dout;
        logic oe;
        logic otype;
        logic pu;
        logic pd;
        logic evtype;
        logic evboth;
        logic even;
        logic even_set;
        logic even_clr;
        logic evst;
        logic ien;
        logic dout_set;
        logic dout_clr;
        logic oe_set;
        logic oe_clr;
        logic lock_b;
    } bank_sel_t;

    typedef struct packed {
        logic [PIN_W-1:0] dout;
        logic [PIN_W-1:0] oe;
        logic [PIN_W-1:0] pol;
        logic [PIN_W-1:0] otype;
        logic [PIN_W-1:0] pu;
        logic [PIN_W-1:0] pd;
        logic [PIN_W-1:0] ien;
        logic [PIN_W-1:0] evtype;
        logic [PIN_W-1:0] evboth;
        logic [PIN_W-1:0] even;
        logic [PIN_W-1:0] evst_clr;
    } bank_regs_t;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    output bank_sel_t         sel_o
);

    always_comb begin
        sel_o          = '0;
        sel_o.lock_a   = (addr_i == ADDR_W'(OFS_LOCK_A));
        sel_o.din      = (addr_i == ADDR_W'(OFS_DIN));
        sel_o.pol      = (addr_i == ADDR_W'(OFS_POL));
        sel_o.dout     = (addr_i == ADDR_W'(OFS_DOUT));
        sel_o.oe       = (addr_i == ADDR_W'(OFS_OE));
        sel_o.otype    = (addr_i == ADDR_W'(OFS_OTYPE));
        sel_o.pu       = (addr_i == ADDR_W'(OFS_PU));
        sel_o.pd       = (addr_i == ADDR_W'(OFS_PD));
        sel_o.evtype   = (addr_i == ADDR_W'(OFS_EVTYPE));
        sel_o.evboth   = (addr_i == ADDR_W'(OFS_EVBOTH));
        sel_o.even     = (addr_i == ADDR_W'(OFS_EVEN));
        sel_o.even_set = (addr_i == ADDR_W'(OFS_EVEN_SET));
        sel_o.even_clr = (addr_i == ADDR_W'(OFS_EVEN_CLR));
        sel_o.evst     = (addr_i == ADDR_W'(OFS_EVST));
        sel_o.ien      = (addr_i == ADDR_W'(OFS_IEN));
        sel_o.dout_set = (addr_i == ADDR_W'(OFS_DOUT_SET));
        sel_o.dout_clr = (addr_i == ADDR_W'(OFS_DOUT_CLR));
        sel_o.oe_set   = (addr_i == ADDR_W'(OFS_OE_SET));
        sel_o.oe_clr   = (addr_i == ADDR_W'(OFS_OE_CLR));
        sel_o.lock_b   = (addr_i == ADDR_W'(OFS_LOCK_B));
    end

    // at most one register is decoded for any offset
    always_comb begin
        AST_ONE_SELECT: assert ($onehot0(sel_o)); // R10
    end

endmodule

// File: rtl/gpio_bank_lock.sv
module gpio_bank_lock
    import gpio_bank_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 32'hC0DE1248,
    parameter logic [DATA_W-1:0] KEY_SECOND = 32'hC0DEFA73
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              sel_a_i,
    input  logic              sel_b_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              locked_o
);

    lock_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (st_q)
                LK_OPEN: if (sel_a_i || sel_b_i) st_d = LK_SHUT;
                LK_SHUT: if (sel_b_i && wdata_i == KEY_FIRST) st_d = LK_HALF;
                LK_HALF: st_d = (sel_a_i && wdata_i == KEY_SECOND) ? LK_OPEN : LK_SHUT;
                default: st_d = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LK_OPEN;
        else        st_q <= st_d;
    end

    assign locked_o = (st_q != LK_OPEN);

    AST_LOCK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_OPEN && wr_i && (sel_a_i || sel_b_i)) |=> locked_o); // R5

    AST_NO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_SHUT) |=> (st_q != LK_OPEN)); // R7

    AST_STRAY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_HALF && wr_i && !(sel_a_i && wdata_i == KEY_SECOND)) |=> (st_q == LK_SHUT)); // R7

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             locked_i,
    input  bank_sel_t        sel_i,
    input  logic [PIN_W-1:0] wdata_i,
    output bank_regs_t       regs_o
);

    bank_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.evst_clr = '0;
        if (wr_i) begin
            if (sel_i.evst) r_d.evst_clr = wdata_i;
            if (!locked_i) begin
                if (sel_i.dout)     r_d.dout   = wdata_i;
                if (sel_i.oe)       r_d.oe     = wdata_i;
                if (sel_i.pol)      r_d.pol    = wdata_i;
                if (sel_i.otype)    r_d.otype  = wdata_i;
                if (sel_i.pu)       r_d.pu     = wdata_i;
                if (sel_i.pd)       r_d.pd     = wdata_i;
                if (sel_i.ien)      r_d.ien    = wdata_i;
                if (sel_i.evtype)   r_d.evtype = wdata_i;
                if (sel_i.evboth)   r_d.evboth = wdata_i;
                if (sel_i.even)     r_d.even   = wdata_i;
                if (sel_i.dout_set) r_d.dout   = r_q.dout | wdata_i;
                if (sel_i.dout_clr) r_d.dout   = r_q.dout & ~wdata_i;
                if (sel_i.oe_set)   r_d.oe     = r_q.oe | wdata_i;
                if (sel_i.oe_clr)   r_d.oe     = r_q.oe & ~wdata_i;
                if (sel_i.even_set) r_d.even   = r_q.even | wdata_i;
                if (sel_i.even_clr) r_d.even   = r_q.even & ~wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.ien <= '1;
        end else begin
            r_q     <= r_d;
        end
    end

    assign regs_o = r_q;

    logic unused_sel;
    assign unused_sel = ^{sel_i.din, sel_i.lock_a, sel_i.lock_b};

    AST_LOCKED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        locked_i |=> ($stable(r_q.dout) && $stable(r_q.oe) && $stable(r_q.pol) && $stable(r_q.otype)
                      && $stable(r_q.pu) && $stable(r_q.pd) && $stable(r_q.ien)
                      && $stable(r_q.evtype) && $stable(r_q.evboth) && $stable(r_q.even))); // R6

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i.dout_set && !locked_i) |=> ((r_q.dout & $past(wdata_i)) == $past(wdata_i))); // R3

    AST_CLR_ANDN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i.oe_clr && !locked_i) |=> ((r_q.oe & $past(wdata_i)) == '0)); // R4

    AST_CLR_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_i.evst) |=> (r_q.evst_clr == '0)); // R8

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_bank_pkg::*;
#(
    parameter int               ADDR_W     = 7,
    parameter logic [PIN_W-1:0] KEY_FIRST  = 32'hC0DE1248,
    parameter logic [PIN_W-1:0] KEY_SECOND = 32'hC0DEFA73
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_level,
    input  logic [PIN_W-1:0]  evt_status,
    output logic [PIN_W-1:0]  cfg_dout,
    output logic [PIN_W-1:0]  cfg_oe,
    output logic [PIN_W-1:0]  cfg_pol,
    output logic [PIN_W-1:0]  cfg_otype,
    output logic [PIN_W-1:0]  cfg_pu,
    output logic [PIN_W-1:0]  cfg_pd,
    output logic [PIN_W-1:0]  cfg_ien,
    output logic [PIN_W-1:0]  cfg_evtype,
    output logic [PIN_W-1:0]  cfg_evboth,
    output logic [PIN_W-1:0]  cfg_even,
    output logic [PIN_W-1:0]  evt_clr,
    output logic              bank_locked
);

    bank_sel_t        sel;
    bank_regs_t       regs;
    logic [PIN_W-1:0] rd_d, rd_q;

    gpio_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    gpio_bank_lock #(
        .DATA_W     (PIN_W),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .sel_a_i  (sel.lock_a),
        .sel_b_i  (sel.lock_b),
        .wdata_i  (bus_wdata),
        .locked_o (bank_locked)
    );

    gpio_bank_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .locked_i (bank_locked),
        .sel_i    (sel),
        .wdata_i  (bus_wdata),
        .regs_o   (regs)
    );

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            rd_d = '0;
            if (sel.lock_a) rd_d = {{(PIN_W-1){1'b0}}, bank_locked};
            if (sel.din)    rd_d = pin_level;
            if (sel.evst)   rd_d = evt_status;
            if (sel.dout)   rd_d = regs.dout;
            if (sel.oe)     rd_d = regs.oe;
            if (sel.pol)    rd_d = regs.pol;
            if (sel.otype)  rd_d = regs.otype;
            if (sel.pu)     rd_d = regs.pu;
            if (sel.pd)     rd_d = regs.pd;
            if (sel.ien)    rd_d = regs.ien;
            if (sel.evtype) rd_d = regs.evtype;
            if (sel.evboth) rd_d = regs.evboth;
            if (sel.even)   rd_d = regs.even;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    logic unused_alias;
    assign unused_alias = ^{sel.lock_b, sel.even_set, sel.even_clr, sel.dout_set,
                            sel.dout_clr, sel.oe_set, sel.oe_clr};

    assign bus_rdata  = rd_q;
    assign cfg_dout   = regs.dout;
    assign cfg_oe     = regs.oe;
    assign cfg_pol    = regs.pol;
    assign cfg_otype  = regs.otype;
    assign cfg_pu     = regs.pu;
    assign cfg_pd     = regs.pd;
    assign cfg_ien    = regs.ien;
    assign cfg_evtype = regs.evtype;
    assign cfg_evboth = regs.evboth;
    assign cfg_even   = regs.even;
    assign evt_clr    = regs.evst_clr;

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10

endmodule

// File: tb/test_gpio_cfg_bank.sv
module test_gpio_cfg_bank;

    localparam logic [31:0] KA = 32'hC0DE1248;
    localparam logic [31:0] KB = 32'hC0DEFA73;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_level = 32'hA5A55A5A;
    logic [31:0] evt_status = 32'h13572468;
    logic [31:0] cfg_dout, cfg_oe, cfg_pol, cfg_otype, cfg_pu, cfg_pd;
    logic [31:0] cfg_ien, cfg_evtype, cfg_evboth, cfg_even, evt_clr;
    logic        bank_locked;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    gpio_cfg_bank i_gpio_cfg_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_level(pin_level), .evt_status(evt_status),
        .cfg_dout(cfg_dout), .cfg_oe(cfg_oe), .cfg_pol(cfg_pol), .cfg_otype(cfg_otype),
        .cfg_pu(cfg_pu), .cfg_pd(cfg_pd), .cfg_ien(cfg_ien), .cfg_evtype(cfg_evtype),
        .cfg_evboth(cfg_evboth), .cfg_even(cfg_even), .evt_clr(evt_clr),
        .bank_locked(bank_locked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver side of the scoreboard: push the expected word, strobe the read
    task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor side: data is due at the negedge after the strobed edge
    always @(posedge clk) begin
        if (bus_rd && rst_n) begin
            @(negedge clk);
            if (exp_q.size() == 0) chk("R10 unexpected read", bus_rdata, 32'hx);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset contents
        chk("R1 ien", cfg_ien, 32'hFFFFFFFF);
        chk("R1 dout", cfg_dout, 32'h0);
        chk("R1 oe", cfg_oe, 32'h0);
        chk("R1 even", cfg_even, 32'h0);
        chk("R1 evt_clr", evt_clr, 32'h0);
        chk("R1 locked", {31'b0, bank_locked}, 32'h0);
        rd(7'h00, 32'h0, "R1 lockA read");
        rd(7'h58, 32'hFFFFFFFF, "R1 ien read");

        // R2 plain registers
        wr(7'h10, 32'h3456789A); chk("R2 oe", cfg_oe, 32'h3456789A);
        wr(7'h0C, 32'h12345678); chk("R2 dout", cfg_dout, 32'h12345678);
        wr(7'h08, 32'h6789ABCD); chk("R2 pol", cfg_pol, 32'h6789ABCD);
        wr(7'h14, 32'h456789AB); chk("R2 otype", cfg_otype, 32'h456789AB);
        wr(7'h1C, 32'hFF00FF00); chk("R2 pu", cfg_pu, 32'hFF00FF00);
        wr(7'h20, 32'h00FF00FF); chk("R2 pd", cfg_pd, 32'h00FF00FF);
        wr(7'h28, 32'hF0F0F0F0); chk("R2 evtype", cfg_evtype, 32'hF0F0F0F0);
        wr(7'h2C, 32'h0F0F0F0F); chk("R2 evboth", cfg_evboth, 32'h0F0F0F0F);
        wr(7'h40, 32'h0F0F0000); chk("R2 even", cfg_even, 32'h0F0F0000);
        wr(7'h58, 32'h87654321); chk("R2 ien", cfg_ien, 32'h87654321);
        rd(7'h10, 32'h3456789A, "R2 oe read");
        rd(7'h0C, 32'h12345678, "R2 dout read");
        rd(7'h08, 32'h6789ABCD, "R2 pol read");
        rd(7'h14, 32'h456789AB, "R2 otype read");
        rd(7'h1C, 32'hFF00FF00, "R2 pu read");
        rd(7'h20, 32'h00FF00FF, "R2 pd read");
        rd(7'h28, 32'hF0F0F0F0, "R2 evtype read");
        rd(7'h2C, 32'h0F0F0F0F, "R2 evboth read");
        rd(7'h40, 32'h0F0F0000, "R2 even read");

        // R4 clear, R3 set aliases
        wr(7'h74, 32'h00030002); chk("R4 oe clr", cfg_oe, 32'h34547898);
        wr(7'h70, 32'h0000F001); chk("R3 oe set", cfg_oe, 32'h3454F899);
        wr(7'h68, 32'h00008000); chk("R3 dout set", cfg_dout, 32'h1234D678);
        wr(7'h6C, 32'h00000078); chk("R4 dout clr", cfg_dout, 32'h1234D600);
        wr(7'h44, 32'h00000200); chk("R3 even set", cfg_even, 32'h0F0F0200);
        wr(7'h48, 32'h0F000000); chk("R4 even clr", cfg_even, 32'h000F0200);
        rd(7'h10, 32'h3454F899, "R3 oe read");

        // R9 inputs read back; write to data-in ignored
        rd(7'h04, 32'hA5A55A5A, "R9 din read");
        rd(7'h4C, 32'h13572468, "R9 evst read");
        wr(7'h04, 32'hFFFFFFFF);
        chk("R9 din write dout", cfg_dout, 32'h1234D600);
        chk("R9 din write oe", cfg_oe, 32'h3454F899);

        // R10 unmapped, misaligned, alias reads
        rd(7'h60, 32'h0, "R10 unmapped read");
        rd(7'h68, 32'h0, "R10 alias read");
        rd(7'h7C, 32'h0, "R10 lockB read");
        wr(7'h60, 32'hFFFFFFFF); chk("R10 unmapped write", cfg_dout, 32'h1234D600);
        wr(7'h0D, 32'hFFFFFFFF); chk("R10 misaligned write", cfg_dout, 32'h1234D600);
        @(negedge clk); chk("R10 hold", bus_rdata, 32'h0);

        // R8 clear pulse
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 7'h4C; bus_wdata = 32'h00FF0F00;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8 pulse", evt_clr, 32'h00FF0F00);
        @(negedge clk); chk("R8 pulse ends", evt_clr, 32'h0);

        // R5 lock via A
        wr(7'h00, 32'h0);
        chk("R5 locked", {31'b0, bank_locked}, 32'h1);
        rd(7'h00, 32'h1, "R5 lockA read");

        // R6 writes blocked
        wr(7'h0C, 32'hA9876543); chk("R6 dout", cfg_dout, 32'h1234D600);
        wr(7'h68, 32'hFFFFFFFF); chk("R6 dout set", cfg_dout, 32'h1234D600);
        wr(7'h74, 32'hFFFFFFFF); chk("R6 oe clr", cfg_oe, 32'h3454F899);
        wr(7'h58, 32'h0);        chk("R6 ien", cfg_ien, 32'h87654321);
        wr(7'h44, 32'hFFFFFFFF); chk("R6 even set", cfg_even, 32'h000F0200);

        // R8 while locked
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 7'h4C; bus_wdata = 32'h10FF0F08;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8 pulse locked", evt_clr, 32'h10FF0F08);

        // R7 bad sequences
        wr(7'h00, KB);
        chk("R7 second key alone", {31'b0, bank_locked}, 32'h1);
        wr(7'h7C, KA); wr(7'h0C, 32'h0); wr(7'h00, KB);
        chk("R7 intervening write", {31'b0, bank_locked}, 32'h1);
        wr(7'h7C, 32'h12345678); wr(7'h00, KB);
        chk("R7 wrong first key", {31'b0, bank_locked}, 32'h1);
        wr(7'h7C, KA); wr(7'h00, 32'h0);
        chk("R7 wrong second key", {31'b0, bank_locked}, 32'h1);
        wr(7'h00, KA); wr(7'h7C, KB);
        chk("R7 swapped keys", {31'b0, bank_locked}, 32'h1);
        chk("R7 dout kept", cfg_dout, 32'h1234D600);

        // R7 proper unlock
        wr(7'h7C, KA); wr(7'h00, KB);
        chk("R7 unlocked", {31'b0, bank_locked}, 32'h0);
        rd(7'h00, 32'h0, "R7 lockA read");
        wr(7'h0C, 32'h98765432); chk("R7 dout after unlock", cfg_dout, 32'h98765432);

        // R5 lock via B with any value, then reopen
        wr(7'h7C, 32'h0);
        chk("R5 locked via B", {31'b0, bank_locked}, 32'h1);
        wr(7'h0C, 32'h0); chk("R6 dout locked again", cfg_dout, 32'h98765432);
        wr(7'h7C, KA); wr(7'h00, KB);
        chk("R7 reopen", {31'b0, bank_locked}, 32'h0);

        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule